// File: doc/BRIEF.md
# CSR Bus Leaf to Single-Cycle Register Access Adapter

This block sits at a leaf of a shared, pipelined control/status register bus. Every request on that bus carries a 16-bit select. The adapter compares the select with a 16-bit value that is tied off at integration. When the two match, the adapter answers the bus handshake and turns it into a one-cycle access strobe toward a plain register block.

The strobe carries the direction, the address and the write data. On a read, the register block answers combinationally, in the strobe cycle, from the address it is given. The adapter registers that word and returns it on the bus with a read-data-valid pulse.

A bus master holds a request valid until it sees acknowledge. The adapter therefore issues exactly one strobe per request. It accepts nothing new until valid has been seen low. While the adapter is not answering, every response output is zero, so several leaves can share one OR-combined response path.

Top module: `csr_leaf_adapter`

## Requirements
- R1: When the adapter is idle and samples `bus_valid_i` high with a matching select on a clock edge, `bus_ack_o` is high for exactly the one cycle after that edge.
- R2: The select comparison uses all 16 bits of `bus_sel_i` against `leaf_sel_i`. Any mismatch, including a single differing bit, produces no acknowledge and no access strobe.
- R3: `acc_valid_o` is high for exactly one cycle, the same cycle as `bus_ack_o`. In that cycle `acc_rnw_o`, `acc_addr_o` and `acc_data_o` equal the request's direction (1 = read), address and write data. Outside the strobe cycle these three outputs are zero.
- R4: One request gives exactly one strobe, even if `bus_valid_i` stays high for many cycles after acknowledge. A new request is accepted once `bus_valid_i` has been sampled low on at least one edge after the acknowledge. One low edge is enough.
- R5: For a read, `acc_rd_data_i` is sampled at the end of the strobe cycle. It appears on `bus_rd_data_o` with `bus_rd_valid_o` high for exactly one cycle, the cycle right after the strobe.
- R6: A write never raises `bus_rd_valid_o`, and `bus_rd_data_o` stays zero across it.
- R7: Whenever `bus_rd_valid_o` is low, `bus_rd_data_o` is zero. `bus_rd_err_o` is always zero. Whenever the adapter is neither acknowledging nor returning read data, all of its bus response outputs are zero.
- R8: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| leaf_sel_i | input | 16 | Tied-off select value of this leaf |
| bus_valid_i | input | 1 | Request valid, held until acknowledged |
| bus_rnw_i | input | 1 | Request direction, 1 = read |
| bus_sel_i | input | 16 | Request select |
| bus_addr_i | input | 16 | Request address |
| bus_data_i | input | 32 | Request write data |
| bus_ack_o | output | 1 | Acknowledge |
| bus_rd_valid_o | output | 1 | Read data valid pulse |
| bus_rd_data_o | output | 32 | Read data, zero when not valid |
| bus_rd_err_o | output | 1 | Read error, always zero |
| acc_valid_o | output | 1 | Single-cycle access strobe |
| acc_rnw_o | output | 1 | Access direction, 1 = read |
| acc_addr_o | output | 16 | Access address |
| acc_data_o | output | 32 | Access write data |
| acc_rd_data_i | input | 32 | Combinational read data from the register block |

## Verification
Call the edge that samples a matching request E0. The acknowledge and the strobe are due one cycle after E0, and read data is due two cycles after E0. The bench drives inputs and samples outputs on the falling edge. Its driver checks the acknowledge on the falling edge that follows E0 and queues the expected strobe and read word. Its monitor compares queued items only in the cycle where `acc_valid_o` or `bus_rd_valid_o` is high. It flags a read pulse that does not come exactly one cycle after a read strobe, and it flags any strobe that arrives with nothing queued.

// File: rtl/csr_leaf_pkg.sv
package csr_leaf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_WAIT   = 2'd2
  } leaf_state_e;
endpackage

// File: rtl/csr_leaf_match.sv
module csr_leaf_match #(
  parameter int SEL_W = 16
) (
  input  logic [SEL_W-1:0] leaf_sel_i,
  input  logic [SEL_W-1:0] bus_sel_i,
  output logic             hit_o
);
  logic [SEL_W-1:0] bit_eq;

  for (genvar i = 0; i < SEL_W; i++) begin : g_bit
    assign bit_eq[i] = ~(leaf_sel_i[i] ^ bus_sel_i[i]);
  end

  assign hit_o = &bit_eq;
endmodule

// File: rtl/csr_leaf_ctrl.sv
module csr_leaf_ctrl
  import csr_leaf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic hit_i,
  output logic accept_o,
  output logic ack_o
);
  leaf_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && req_valid_i && hit_i;
  assign ack_o    = (state_q == ST_ACCESS);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_o) state_d = ST_ACCESS;
      // a master that already dropped valid may reissue right away
      ST_ACCESS: state_d = req_valid_i ? ST_WAIT : ST_IDLE;
      ST_WAIT:   if (!req_valid_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R1
  p_ack_on_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_valid_i && hit_i) |=> ack_o);
  p_ack_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R2
  p_no_ack_mismatch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit_i) |=> !ack_o);
  // R4
  p_hold_no_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && req_valid_i) |=> (!ack_o && !accept_o));
endmodule

// File: rtl/csr_leaf_access.sv
module csr_leaf_access #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              acc_valid_o,
  output logic              acc_rnw_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [DATA_W-1:0] acc_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_valid_o <= 1'b0;
      acc_rnw_o   <= 1'b0;
      acc_addr_o  <= '0;
      acc_data_o  <= '0;
    end else if (accept_i) begin
      acc_valid_o <= 1'b1;
      acc_rnw_o   <= rnw_i;
      acc_addr_o  <= addr_i;
      acc_data_o  <= data_i;
    end else begin
      acc_valid_o <= 1'b0;
      acc_rnw_o   <= 1'b0;
      acc_addr_o  <= '0;
      acc_data_o  <= '0;
    end
  end

  // R3
  p_strobe_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o |=> !acc_valid_o);
  p_fields_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_o |-> (!acc_rnw_o && acc_addr_o == '0 && acc_data_o == '0));
  p_fields_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> (acc_valid_o && acc_addr_o == $past(addr_i) && acc_rnw_o == $past(rnw_i)));
endmodule

// File: rtl/csr_leaf_resp.sv
module csr_leaf_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_rnw_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic take_rd;
  assign take_rd = acc_valid_i && acc_rnw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= take_rd;
      rd_data_o  <= take_rd ? rd_data_i : '0;
    end
  end

  // R5
  p_read_return_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_rd |=> (rd_valid_o && rd_data_o == $past(rd_data_i)));
  // R6
  p_write_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_rnw_i) |=> !rd_valid_o);
  // R7
  p_data_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> rd_data_o == '0);
endmodule

// File: rtl/csr_leaf_adapter.sv
module csr_leaf_adapter #(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  leaf_sel_i,
  input  logic              bus_valid_i,
  input  logic              bus_rnw_i,
  input  logic [SEL_W-1:0]  bus_sel_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              bus_ack_o,
  output logic              bus_rd_valid_o,
  output logic [DATA_W-1:0] bus_rd_data_o,
  output logic              bus_rd_err_o,
  output logic              acc_valid_o,
  output logic              acc_rnw_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [DATA_W-1:0] acc_data_o,
  input  logic [DATA_W-1:0] acc_rd_data_i
);
  logic hit, accept;

  csr_leaf_match #(.SEL_W(SEL_W)) i_match (
    .leaf_sel_i (leaf_sel_i),
    .bus_sel_i  (bus_sel_i),
    .hit_o      (hit)
  );

  csr_leaf_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (bus_valid_i),
    .hit_i       (hit),
    .accept_o    (accept),
    .ack_o       (bus_ack_o)
  );

  csr_leaf_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_access (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .rnw_i       (bus_rnw_i),
    .addr_i      (bus_addr_i),
    .data_i      (bus_data_i),
    .acc_valid_o (acc_valid_o),
    .acc_rnw_o   (acc_rnw_o),
    .acc_addr_o  (acc_addr_o),
    .acc_data_o  (acc_data_o)
  );

  csr_leaf_resp #(.DATA_W(DATA_W)) i_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_o),
    .acc_rnw_i   (acc_rnw_o),
    .rd_data_i   (acc_rd_data_i),
    .rd_valid_o  (bus_rd_valid_o),
    .rd_data_o   (bus_rd_data_o)
  );

  assign bus_rd_err_o = 1'b0;

  // R3: strobe and acknowledge coincide (separate flops)
  p_ack_with_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o == acc_valid_o);
  // R7: ack and read pulse never overlap
  p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_ack_o && bus_rd_valid_o));
endmodule

// File: tb/test_csr_leaf_adapter.sv
module test_csr_leaf_adapter;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MY_SEL = 16'h3c41;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_rnw = 1'b0;
  logic [15:0] bus_sel = '0, bus_addr = '0;
  logic [31:0] bus_data = '0;
  logic        ack, rd_valid, rd_err, acc_valid, acc_rnw;
  logic [31:0] rd_data, acc_data, acc_rd_data;
  logic [15:0] acc_addr;

  int checks = 0, errors = 0, cycles = 0;
  logic [48:0] acc_q[$];
  logic [31:0] rd_q[$];
  logic        prev_rd_strobe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model(logic [15:0] a);
    return {a ^ 16'hc3a5, ~a};
  endfunction

  // register block: combinational read, junk when not strobed
  assign acc_rd_data = acc_valid ? model(acc_addr) : 32'hffff_ffff;

  csr_leaf_adapter i_csr_leaf_adapter (
    .clk_i(clk), .rst_ni(rst_n), .leaf_sel_i(MY_SEL),
    .bus_valid_i(bus_valid), .bus_rnw_i(bus_rnw), .bus_sel_i(bus_sel),
    .bus_addr_i(bus_addr), .bus_data_i(bus_data),
    .bus_ack_o(ack), .bus_rd_valid_o(rd_valid), .bus_rd_data_o(rd_data),
    .bus_rd_err_o(rd_err), .acc_valid_o(acc_valid), .acc_rnw_o(acc_rnw),
    .acc_addr_o(acc_addr), .acc_data_o(acc_data), .acc_rd_data_i(acc_rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (acc_valid) begin
        if (acc_q.size() == 0) chk(0, "R4 unexpected strobe", {acc_rnw, acc_addr, acc_data}, 0);
        else begin
          logic [48:0] e;
          e = acc_q.pop_front();
          chk({acc_rnw, acc_addr, acc_data} == e, "R3 strobe fields", {acc_rnw, acc_addr, acc_data}, e);
        end
        chk(ack, "R3 ack with strobe", ack, 1);
      end else if (acc_rnw || acc_addr != 0 || acc_data != 0)
        chk(0, "R3 fields not zero", {acc_rnw, acc_addr, acc_data}, 0);
      if (rd_valid != prev_rd_strobe)
        chk(0, "R5 read pulse timing", rd_valid, prev_rd_strobe);
      if (rd_valid) begin
        if (rd_q.size() == 0) chk(0, "R6 unexpected read data", rd_data, 0);
        else begin
          logic [31:0] e;
          e = rd_q.pop_front();
          chk(rd_data == e, "R5 read data", rd_data, e);
        end
      end else if (rd_data != 0) chk(0, "R7 idle read data", rd_data, 0);
      if (rd_err) chk(0, "R7 err", rd_err, 0);
      prev_rd_strobe = acc_valid && acc_rnw;
    end
  end

  task automatic send(input bit rnw, input logic [15:0] sel, input logic [15:0] addr,
                      input logic [31:0] data, input int extra);
    bit hit;
    hit = (sel == MY_SEL);
    @(negedge clk);
    bus_valid = 1; bus_rnw = rnw; bus_sel = sel; bus_addr = addr; bus_data = data;
    if (hit) begin
      acc_q.push_back({rnw, addr, data});
      if (rnw) rd_q.push_back(model(addr));
    end
    @(negedge clk);
    chk(ack == hit, hit ? "R1 ack" : "R2 no ack", ack, hit);
    repeat (hit ? extra : 3) begin
      @(negedge clk);
      chk(!ack, hit ? "R4 no re-ack while held" : "R2 no ack", ack, 0);
    end
    bus_valid = 0; bus_rnw = 0; bus_sel = '0; bus_addr = '0; bus_data = '0;
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk({ack, rd_valid, rd_data, rd_err, acc_valid, acc_rnw, acc_addr, acc_data} == 0,
          "R8 reset", {ack, rd_valid, acc_valid, acc_rnw}, 0);
    end
    rst_n = 1;
    @(negedge clk);
    chk(!ack && !rd_valid && rd_data == 0, "R7 idle after reset", rd_data, 0);

    send(1, MY_SEL, 16'h0010, 32'h0, 0);                  // R5 read
    send(0, MY_SEL, 16'h0024, 32'hcafe_f00d, 0);          // R6 write, back to back
    send(1, MY_SEL, 16'hffff, 32'h1234_5678, 0);          // R5 read, min gap
    send(1, MY_SEL ^ 16'h8000, 16'h0001, 32'h0, 0);       // R2 top bit differs
    send(0, MY_SEL ^ 16'h0001, 16'h0002, 32'h5, 0);       // R2 bottom bit differs
    send(1, MY_SEL, 16'h0aa0, 32'h0, 4);                  // R4 held valid
    send(0, MY_SEL, 16'h0bb0, 32'h8765_4321, 6);          // R4 held write
    send(1, MY_SEL, 16'h0000, 32'h0, 1);                  // R4 one-low-edge restart
    repeat (2) @(negedge clk);
    chk(!ack && !rd_valid && rd_data == 0 && !acc_valid, "R7 quiet", rd_data, 0);
    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [15:0] s;
      s = ($urandom_range(0, 2) == 0) ? MY_SEL ^ (16'h1 << $urandom_range(0, 15)) : MY_SEL;
      send($urandom_range(0, 1), s, 16'($urandom), $urandom, $urandom_range(0, 3));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(acc_q.size() == 0, "R3 missing strobe", acc_q.size(), 0);
    chk(rd_q.size() == 0, "R5 missing read", rd_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule